// File: doc/BRIEF.md
# Security Code Verification Unit

This block guards write and erase access to a small nonvolatile store. It keeps a short failure counter and a multi-byte access code in nonvolatile cells. A host presents a candidate code. The unit compares it with the stored one as a single unit. A match opens write permission for the memory controller. Each miss removes one of the remaining attempts. When no attempts are left the unit locks for good, and no further compare, counter write or code write can reopen it.

The same unit drives the readout path for its own bytes. The counter byte can always be read. The stored code bytes read as zero until a compare has succeeded. Two resets are separate. The power-on reset only withdraws the verified state. The delivery-state load returns the nonvolatile cells to their factory values. Because the lock is decoded from a zero counter, it survives any number of power-on resets.

Top module: `sc_guard`

## Requirements
- R1: While power-on reset `rst_n` is low, and after it is released, `verified` is 0, `code_hidden` is 1 and `wr_grant` is 0. The counter and the stored code keep their values.
- R2: A compare request made while the counter is nonzero, with `cmp_code` equal to the stored code, sets `verified` to 1 and the counter to all ones on the next clock edge. Byte k of the code is `cmp_code[8k+7:8k]`.
- R3: A compare request made while the counter is nonzero, with a mismatching code, clears the lowest set bit of the counter and sets `verified` to 0 on the next clock edge. From the full value the counter steps 111, 110, 100, 000.
- R4: `locked` is 1 exactly when the counter is zero. Once locked, a compare request has no effect, even with the right code: the counter stays 0 and `verified` does not rise.
- R5: `wr_grant` is 1 exactly when `verified` is 1 and `locked` is 0.
- R6: With `rd_sel` = 0, `rd_data` shows the counter in bits 2:0 and zeros above, whatever the verification state.
- R7: With `rd_sel` = k (1 to 3), `rd_data` shows stored code byte k-1 when `verified` is 1. Otherwise it shows 0x00, and `code_hidden` is 1.
- R8: A counter write with `wr_grant` high loads `ctr_wr_val`. Without grant, it can only clear bits: the new counter is the old counter AND `ctr_wr_val`.
- R9: A code write stores `code_wr_byte` into byte `code_wr_idx` (0 to 2) only when `wr_grant` is high. Without grant, or with index 3, it leaves every stored byte unchanged.
- R10: In a cycle with more than one request, a compare takes precedence over a counter write, and a counter write takes precedence over a code write. Only the winning request has an effect.
- R11: The locked state persists across power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous; clears the verified state |
| nv_rst_n | input | 1 | Delivery-state load, active low; loads the factory counter and code |
| cmp_req | input | 1 | Compare request |
| cmp_code | input | 24 | Presented code, byte k in bits 8k+7:8k |
| ctr_wr_req | input | 1 | Counter write request |
| ctr_wr_val | input | 3 | Counter write value |
| code_wr_req | input | 1 | Code byte write request |
| code_wr_idx | input | 2 | Code byte index (0 to 2) |
| code_wr_byte | input | 8 | Code byte value |
| rd_sel | input | 2 | Readout select: 0 counter byte, 1 to 3 code bytes |
| verified | output | 1 | Code has been verified since power-on |
| locked | output | 1 | Counter exhausted, permanent lock |
| err_ctr | output | 3 | Remaining-attempt counter |
| wr_grant | output | 1 | Write/erase permission to the memory controller |
| code_hidden | output | 1 | Code bytes masked on readout |
| rd_data | output | 8 | Readout byte |

## Verification
The assertions assume that `nv_rst_n` is pulsed once, before any request. They also assume that no request is made while either reset is low. Each rule is checked at the clock edge that follows a request, so a request is taken to be a one-cycle pulse, sampled with the state of that same edge. The stimulus respects this: every request lasts exactly one cycle and is followed by a quiet check cycle. The delivery load is used only at start-up. Later resets pull only `rst_n`, which keeps the lock persistence observable at the ports.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int DEF_BYTE_W     = 8;
    localparam int DEF_CODE_BYTES = 3;
    localparam int DEF_CTR_W      = 3;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CMP  = 2'd1,
        OP_CTR  = 2'd2,
        OP_CODE = 2'd3
    } sc_op_e;
endpackage

// File: rtl/sc_code_match.sv
module sc_code_match #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3,
    localparam int W = BYTE_W * NBYTES
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] ref_code,
    output logic         match
);
    logic [NBYTES-1:0] byte_eq;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign byte_eq[k] = (cand[k*BYTE_W +: BYTE_W] == ref_code[k*BYTE_W +: BYTE_W]);
    end

    // The code is accepted only as a whole
    assign match = &byte_eq;
endmodule

// File: rtl/sc_ctr_next.sv
module sc_ctr_next #(
    parameter int W = 3
) (
    input  logic [W-1:0] ctr,
    input  logic         is_cmp,
    input  logic         match,
    input  logic         granted,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] ctr_nxt
);
    logic exhausted;
    assign exhausted = (ctr == '0);

    always_comb begin
        if (is_cmp) begin
            if (exhausted)  ctr_nxt = ctr;
            else if (match) ctr_nxt = '1;
            else            ctr_nxt = ctr & (ctr - 1'b1);   // drop lowest set bit
        end else begin
            // Without grant the counter can only lose bits
            ctr_nxt = granted ? wr_val : (ctr & wr_val);
        end
    end
endmodule

// File: rtl/sc_read_sel.sv
module sc_read_sel #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3,
    parameter int CTR_W  = 3,
    parameter int SEL_W  = 2,
    localparam int W = BYTE_W * NBYTES
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [CTR_W-1:0]  ctr,
    input  logic [W-1:0]      code,
    input  logic              show,
    output logic [BYTE_W-1:0] dout
);
    logic [BYTE_W-1:0] cand [NBYTES+1];

    assign cand[0] = BYTE_W'(ctr);

    for (genvar k = 0; k < NBYTES; k++) begin : g_mask
        assign cand[k+1] = show ? code[k*BYTE_W +: BYTE_W] : '0;
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i <= NBYTES; i++) begin
            if (sel == SEL_W'(i)) dout = cand[i];
        end
    end
endmodule

// File: rtl/sc_guard.sv
module sc_guard
    import sc_pkg::*;
#(
    parameter int BYTE_W     = DEF_BYTE_W,
    parameter int CODE_BYTES = DEF_CODE_BYTES,
    parameter int CTR_W      = DEF_CTR_W,
    parameter logic [BYTE_W*CODE_BYTES-1:0] INIT_CODE = 24'h3C_96_A5,
    parameter logic [CTR_W-1:0]             INIT_CTR  = '1,
    localparam int CODE_W = BYTE_W * CODE_BYTES,
    localparam int SEL_W  = $clog2(CODE_BYTES + 1),
    localparam int IDX_W  = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_rst_n,
    input  logic              cmp_req,
    input  logic [CODE_W-1:0] cmp_code,
    input  logic              ctr_wr_req,
    input  logic [CTR_W-1:0]  ctr_wr_val,
    input  logic              code_wr_req,
    input  logic [IDX_W-1:0]  code_wr_idx,
    input  logic [BYTE_W-1:0] code_wr_byte,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic              verified,
    output logic              locked,
    output logic [CTR_W-1:0]  err_ctr,
    output logic              wr_grant,
    output logic              code_hidden,
    output logic [BYTE_W-1:0] rd_data
);
    typedef struct packed {
        logic verified;
    } vol_t;

    typedef struct packed {
        logic [CTR_W-1:0]  ctr;
        logic [CODE_W-1:0] code;
    } nv_t;

    vol_t vol_d, vol_q;
    nv_t  nv_d,  nv_q;

    sc_op_e            op;
    logic              code_ok;
    logic [CTR_W-1:0]  ctr_nxt;
    logic [CODE_W-1:0] code_flat;
    logic              granted;
    logic              exhausted;

    assign code_flat = nv_q.code;
    assign exhausted = (nv_q.ctr == '0);
    assign granted   = vol_q.verified && !exhausted;

    // Request priority: compare, then counter write, then code write
    always_comb begin
        if (cmp_req)          op = OP_CMP;
        else if (ctr_wr_req)  op = OP_CTR;
        else if (code_wr_req) op = OP_CODE;
        else                  op = OP_NONE;
    end

    sc_code_match #(
        .BYTE_W (BYTE_W),
        .NBYTES (CODE_BYTES)
    ) u_match (
        .cand     (cmp_code),
        .ref_code (code_flat),
        .match    (code_ok)
    );

    sc_ctr_next #(
        .W (CTR_W)
    ) u_ctr (
        .ctr     (nv_q.ctr),
        .is_cmp  (op == OP_CMP),
        .match   (code_ok),
        .granted (granted),
        .wr_val  (ctr_wr_val),
        .ctr_nxt (ctr_nxt)
    );

    always_comb begin
        vol_d = vol_q;
        nv_d  = nv_q;
        unique case (op)
            OP_CMP: begin
                if (!exhausted) begin
                    vol_d.verified = code_ok;
                    nv_d.ctr       = ctr_nxt;
                end
            end
            OP_CTR: begin
                nv_d.ctr = ctr_nxt;
            end
            OP_CODE: begin
                if (granted) begin
                    for (int k = 0; k < CODE_BYTES; k++) begin
                        if (code_wr_idx == IDX_W'(k))
                            nv_d.code[k*BYTE_W +: BYTE_W] = code_wr_byte;
                    end
                end
            end
            default: ;
        endcase
    end

    // Volatile state: cleared by power-on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vol_q <= '0;
        else        vol_q <= vol_d;
    end

    // Nonvolatile cells: only the delivery-state load touches them
    always_ff @(posedge clk or negedge nv_rst_n) begin
        if (!nv_rst_n) begin
            nv_q.ctr  <= INIT_CTR;
            nv_q.code <= INIT_CODE;
        end else begin
            nv_q <= nv_d;
        end
    end

    sc_read_sel #(
        .BYTE_W (BYTE_W),
        .NBYTES (CODE_BYTES),
        .CTR_W  (CTR_W),
        .SEL_W  (SEL_W)
    ) u_rd (
        .sel  (rd_sel),
        .ctr  (nv_q.ctr),
        .code (nv_q.code),
        .show (vol_q.verified),
        .dout (rd_data)
    );

    assign verified    = vol_q.verified;
    assign locked      = exhausted;
    assign err_ctr     = nv_q.ctr;
    assign wr_grant    = granted;
    assign code_hidden = !vol_q.verified;
endmodule

// File: rtl/sc_guard_chk.sv
module sc_guard_chk #(
    parameter int BYTE_W = 8,
    parameter int CODE_W = 24,
    parameter int CTR_W  = 3,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_rst_n,
    input logic              cmp_req,
    input logic [CODE_W-1:0] cmp_code,
    input logic              ctr_wr_req,
    input logic [SEL_W-1:0]  rd_sel,
    input logic              verified,
    input logic              locked,
    input logic [CTR_W-1:0]  err_ctr,
    input logic              wr_grant,
    input logic [BYTE_W-1:0] rd_data,
    input logic [CODE_W-1:0] stored_code
);
    a_r1_por_clears: assert property (@(posedge clk)
        $rose(rst_n) |-> !verified && !wr_grant);

    a_r2_match_restores: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        cmp_req && err_ctr != '0 && cmp_code == stored_code |=> verified && err_ctr == '1);

    a_r3_miss_clears_one: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        cmp_req && err_ctr != '0 && cmp_code != stored_code
        |=> !verified && err_ctr == ($past(err_ctr) & ($past(err_ctr) - 1'b1)));

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        locked |=> locked && err_ctr == '0);

    a_r4_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        locked |-> !wr_grant);

    a_r6_ctr_visible: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        rd_sel == '0 |-> rd_data == BYTE_W'(err_ctr));

    a_r7_code_masked: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        !verified && rd_sel != '0 |-> rd_data == '0);

    a_r8_no_raise: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        !wr_grant && !cmp_req && ctr_wr_req |=> (err_ctr & ~$past(err_ctr)) == '0);
endmodule

bind sc_guard sc_guard_chk #(
    .BYTE_W (BYTE_W),
    .CODE_W (CODE_W),
    .CTR_W  (CTR_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nv_rst_n    (nv_rst_n),
    .cmp_req     (cmp_req),
    .cmp_code    (cmp_code),
    .ctr_wr_req  (ctr_wr_req),
    .rd_sel      (rd_sel),
    .verified    (verified),
    .locked      (locked),
    .err_ctr     (err_ctr),
    .wr_grant    (wr_grant),
    .rd_data     (rd_data),
    .stored_code (code_flat)
);

// File: tb/test_sc_guard.sv
module test_sc_guard;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, nv_rst_n = 1'b0;
    logic        cmp_req = 1'b0, ctr_wr_req = 1'b0, code_wr_req = 1'b0;
    logic [23:0] cmp_code = '0;
    logic [2:0]  ctr_wr_val = '0;
    logic [1:0]  code_wr_idx = '0, rd_sel = '0;
    logic [7:0]  code_wr_byte = '0;
    logic        verified, locked, wr_grant, code_hidden;
    logic [2:0]  err_ctr;
    logic [7:0]  rd_data;

    always #(CLK_P/2) clk = ~clk;

    sc_guard i_sc_guard (
        .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n),
        .cmp_req(cmp_req), .cmp_code(cmp_code),
        .ctr_wr_req(ctr_wr_req), .ctr_wr_val(ctr_wr_val),
        .code_wr_req(code_wr_req), .code_wr_idx(code_wr_idx), .code_wr_byte(code_wr_byte),
        .rd_sel(rd_sel), .verified(verified), .locked(locked), .err_ctr(err_ctr),
        .wr_grant(wr_grant), .code_hidden(code_hidden), .rd_data(rd_data)
    );

    typedef struct {
        string      tag;
        logic       v;
        logic [2:0] c;
        logic [7:0] rd;
    } exp_t;

    exp_t q[$];
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    // Reference state, built from the requirements
    logic [2:0] m_ctr = 3'b111;
    logic       m_ver = 1'b0;
    logic [7:0] m_code [3] = '{8'hA5, 8'h96, 8'h3C};

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares outputs on the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "verified",    8'(verified),    8'(e.v));
            chk(e.tag, "code_hidden", 8'(code_hidden), 8'(!e.v));
            chk(e.tag, "err_ctr",     8'(err_ctr),     8'(e.c));
            chk(e.tag, "locked",      8'(locked),      8'(e.c == 3'b000));
            chk(e.tag, "wr_grant",    8'(wr_grant),    8'(e.v && e.c != 3'b000));
            chk(e.tag, "rd_data",     rd_data,         e.rd);
        end
    end

    function automatic logic [23:0] model_code();
        return {m_code[2], m_code[1], m_code[0]};
    endfunction

    // Driver: one request cycle, then a quiet cycle whose outputs are checked
    task automatic step(bit cmp, logic [23:0] code, bit cw, logic [2:0] cwv,
                        bit kw, logic [1:0] kidx, logic [7:0] kb,
                        logic [1:0] sel, string tag);
        exp_t e;
        bit   grant;
        @(posedge clk); #1;
        cmp_req = cmp; cmp_code = code;
        ctr_wr_req = cw; ctr_wr_val = cwv;
        code_wr_req = kw; code_wr_idx = kidx; code_wr_byte = kb;
        @(posedge clk); #1;
        cmp_req = 1'b0; ctr_wr_req = 1'b0; code_wr_req = 1'b0;
        rd_sel = sel;
        grant = m_ver && (m_ctr != 3'b000);
        if (cmp) begin
            if (m_ctr != 3'b000) begin
                if (code == model_code()) begin m_ctr = 3'b111; m_ver = 1'b1; end
                else begin m_ctr = m_ctr & (m_ctr - 3'd1); m_ver = 1'b0; end
            end
        end else if (cw) begin
            m_ctr = grant ? cwv : (m_ctr & cwv);
        end else if (kw && grant && kidx != 2'd3) begin
            m_code[kidx] = kb;
        end
        e.tag = tag;
        e.v   = m_ver;
        e.c   = m_ctr;
        if (sel == 2'd0) e.rd = {5'b0, m_ctr};
        else             e.rd = m_ver ? m_code[sel - 2'd1] : 8'h00;
        q.push_back(e);
    endtask

    task automatic look(logic [1:0] sel, string tag);
        step(0, '0, 0, '0, 0, '0, '0, sel, tag);
    endtask

    task automatic por();
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        m_ver = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1; nv_rst_n = 1'b1;

        look(2'd0, "R1 reset state, R6 counter byte");
        look(2'd1, "R7 code byte hidden before verify");
        step(0, '0, 1, 3'b101, 0, '0, '0, 2'd0, "R8 ungranted write clears bits");
        step(0, '0, 1, 3'b111, 0, '0, '0, 2'd0, "R8 ungranted write cannot raise bits");
        step(0, '0, 0, '0, 1, 2'd0, 8'h11, 2'd0, "R9 ungranted code write");
        step(1, 24'h3C96A4, 0, '0, 0, '0, '0, 2'd0, "R3 mismatch clears lowest bit");
        step(1, 24'h3C96A5, 0, '0, 0, '0, '0, 2'd1, "R2 match verifies, R5 grant, R9 byte0 unchanged");
        look(2'd2, "R7 code byte 1 visible");
        look(2'd3, "R7 code byte 2 visible");
        step(0, '0, 0, '0, 1, 2'd1, 8'h77, 2'd2, "R9 granted code write");
        step(0, '0, 0, '0, 1, 2'd3, 8'hEE, 2'd1, "R9 index 3 ignored byte0");
        look(2'd2, "R9 index 3 ignored byte1");
        look(2'd3, "R9 index 3 ignored byte2");
        step(0, '0, 1, 3'b011, 0, '0, '0, 2'd0, "R8 granted counter load");
        step(1, 24'h3C77A5, 1, 3'b001, 1, 2'd0, 8'h00, 2'd1, "R10 compare wins over writes");
        por();
        look(2'd2, "R1 power-on reset clears verify, keeps cells");
        step(1, 24'h000000, 0, '0, 0, '0, '0, 2'd0, "R3 miss 1");
        step(1, 24'h000001, 0, '0, 0, '0, '0, 2'd0, "R3 miss 2");
        step(1, 24'h000002, 0, '0, 0, '0, '0, 2'd0, "R3 miss 3, R4 locked");
        step(1, 24'h3C77A5, 0, '0, 0, '0, '0, 2'd1, "R4 compare ignored when locked");
        step(0, '0, 1, 3'b111, 0, '0, '0, 2'd0, "R4 R8 locked counter stays zero");
        por();
        look(2'd0, "R11 lock persists across reset, R6");
        look(2'd3, "R11 R7 hidden while locked");

        @(posedge clk); @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule